// File: doc/BRIEF.md
# Host Bus Event Capture and Interrupt Latch

This block sits on the address and data lines of an 8-bit host with a 13-bit address space. It watches one qualified strobe per host bus cycle. When an access lands in one of several decoded regions, it stores an 8-bit tag and an 8-bit payload. It then raises an interrupt request towards a companion processor. The companion reads the two registers and acknowledges. Which bus fields feed the tag and the payload depends on the region. In the wide write region the payload is built from address bits alone, so the host can hand over a byte with a single store whose data value does not matter.

The host address is registered on the strobe, and every region decode works on that registered copy. Each strobe therefore produces at most one capture, two rising edges after the strobe cycle. If a capture arrives while a request is still pending, it is dropped and a sticky overrun flag is raised in its place.

A separate two-address read window returns a status byte to the host: a 4-bit audio sample plus two companion status flags. The window drives only the six bits it owns, and only after software has set an enable. This keeps it off the bus on hosts that already drive those addresses.

Top module: `hotspot_capture`

## Requirements
- R1: Any access, read or write, to 0x1F00-0x1FFF captures tag = address bits 7:0 and payload = the data bus, and sets `irq_req`. The new values appear after the second rising edge that follows the strobe cycle.
- R2: A write to 0x0030-0x003F captures tag = {4'h0, address bits 3:0} and payload = the data bus.
- R3: A write to 0x0040-0x007F captures tag = 8'h00 and payload = the data bus.
- R4: A write to 0x0400-0x0FFF captures tag = {4'h0, address bits 11:8} and payload = address bits 7:0.
- R5: A read of 0x0030-0x0FFF, or any access outside the listed regions, captures nothing and leaves `irq_req` unchanged.
- R6: `irq_req` stays high until `irq_ack` is sampled high. That edge clears both `irq_req` and `irq_overrun` unless a capture coincides with it.
- R7: A capture that arrives while `irq_req` is high, with no acknowledge in the same cycle, leaves tag and payload unchanged and sets `irq_overrun`.
- R8: When a capture and an acknowledge fall on the same edge, the new tag and payload are stored, `irq_req` stays high and `irq_overrun` is cleared.
- R9: With `win_en` high, a read (`bus_rnw` = 1) of 0x019 or 0x01A gives `rd_oe` = 8'h3F. In that case `rd_data` bit 5 = `cmd_ready`, bits 4:1 = `aud_sample`, bit 0 = `cmd_idle`, and bits 7:6 = 0. This is combinational in the same cycle.
- R10: With `win_en` low, on a write, or at any other address, `rd_oe` and `rd_data` are 8'h00.
- R11: When `bus_strobe` is low, no capture is made, whatever the bus carries.
- R12: After reset, `irq_req` and `irq_overrun` are 0 and tag and payload are 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_strobe | input | 1 | One-cycle qualifier marking a valid host bus cycle |
| bus_addr | input | 13 | Host address |
| bus_wdata | input | 8 | Host data bus value |
| bus_rnw | input | 1 | 1 = host read, 0 = host write |
| irq_ack | input | 1 | Companion acknowledge pulse |
| win_en | input | 1 | Software enable for the status read window |
| aud_sample | input | 4 | Current audio sample from the companion |
| cmd_ready | input | 1 | Companion can accept commands |
| cmd_idle | input | 1 | Companion has drained all commands |
| irq_req | output | 1 | Interrupt request to the companion |
| irq_overrun | output | 1 | Sticky flag: a capture was dropped |
| cap_tag | output | 8 | Captured tag |
| cap_data | output | 8 | Captured payload |
| rd_data | output | 8 | Read-window data to the host |
| rd_oe | output | 8 | Per-bit output enable for `rd_data` |

## Verification
A wrong region decode shows at the ports as a tag or payload taken from the wrong field. It also shows as a request raised or missed after a read. Either way it is visible two edges after the offending strobe. A fault in the pending logic shows on the next capture that arrives while a request is still up: registers are overwritten, overrun is missing, or the request is lost when an acknowledge and a capture land together. Read-window faults are combinational and appear in the same cycle as a wrong enable mask or a misplaced status bit.

// File: rtl/hs_pkg.sv
package hs_pkg;
  parameter int AW = 13;
  parameter int DW = 8;

  typedef enum logic [2:0] {RG_NONE, RG_HOT, RG_NIB, RG_TRIG, RG_WIDE} region_t;

  function automatic region_t classify(input logic [AW-1:0] a, input logic rnw,
                                       input logic [AW-9:0] hot_page);
    region_t r;
    r = RG_NONE;
    if (a[AW-1:8] == hot_page) r = RG_HOT;
    else if (!rnw) begin
      if (a >= AW'('h0030) && a <= AW'('h003F)) r = RG_NIB;
      else if (a >= AW'('h0040) && a <= AW'('h007F)) r = RG_TRIG;
      else if (a >= AW'('h0400) && a <= AW'('h0FFF)) r = RG_WIDE;
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] pick_tag(input region_t r, input logic [AW-1:0] a);
    case (r)
      RG_HOT:  return a[7:0];
      RG_NIB:  return {4'h0, a[3:0]};
      RG_WIDE: return {4'h0, a[11:8]};
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] pick_pay(input region_t r, input logic [AW-1:0] a,
                                             input logic [DW-1:0] d);
    return (r == RG_WIDE) ? a[7:0] : d;
  endfunction
endpackage

// File: rtl/hs_stage.sv
module hs_stage import hs_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          rnw,
  output logic          s_vld,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_data,
  output logic          s_rnw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld  <= 1'b0;
      s_addr <= '0;
      s_data <= '0;
      s_rnw  <= 1'b1;
    end else begin
      s_vld <= strobe;
      if (strobe) begin
        s_addr <= addr;
        s_data <= data;
        s_rnw  <= rnw;
      end
    end
  end
endmodule

// File: rtl/hs_decode.sv
module hs_decode import hs_pkg::*; #(
  parameter logic [AW-9:0] HOT_PAGE = 5'h1F
) (
  input  logic          s_vld,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_data,
  input  logic          s_rnw,
  output logic          hit,
  output logic [DW-1:0] hit_tag,
  output logic [DW-1:0] hit_pay
);
  region_t reg_sel;
  always_comb begin
    reg_sel = classify(s_addr, s_rnw, HOT_PAGE);
    hit     = s_vld && (reg_sel != RG_NONE);
    hit_tag = pick_tag(reg_sel, s_addr);
    hit_pay = pick_pay(reg_sel, s_addr, s_data);
  end
endmodule

// File: rtl/hs_capture.sv
module hs_capture import hs_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [DW-1:0] hit_tag,
  input  logic [DW-1:0] hit_pay,
  input  logic          ack,
  output logic          irq,
  output logic          ovr,
  output logic [DW-1:0] tag_q,
  output logic [DW-1:0] pay_q
);
  logic take;
  assign take = hit && (!irq || ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      ovr   <= 1'b0;
      tag_q <= '0;
      pay_q <= '0;
    end else begin
      if (take) begin
        tag_q <= hit_tag;
        pay_q <= hit_pay;
        irq   <= 1'b1;
        if (ack) ovr <= 1'b0;
      end else if (hit) begin
        ovr <= 1'b1;
      end else if (ack) begin
        irq <= 1'b0;
        ovr <= 1'b0;
      end
    end
  end

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack |=> irq);
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !hit |=> !irq && !ovr);
  p_pend_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack && hit |=> $stable(tag_q) && $stable(pay_q) && ovr && irq);
  p_coincide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack && hit |=> irq && !ovr);
endmodule

// File: rtl/hs_rdwin.sv
module hs_rdwin import hs_pkg::*; #(
  parameter logic [AW-1:0] WIN_LO = 13'h019,
  parameter logic [AW-1:0] WIN_HI = 13'h01A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic          rnw,
  input  logic [3:0]    sample,
  input  logic          ready,
  input  logic          idle,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] rd_oe
);
  logic sel;
  always_comb begin
    sel     = en && rnw && (addr >= WIN_LO) && (addr <= WIN_HI);
    rd_oe   = sel ? 8'h3F : 8'h00;
    rd_data = sel ? {2'b00, ready, sample, idle} : 8'h00;
  end

  p_oe_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe == 8'h00) || (rd_oe == 8'h3F));
  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> rd_oe == 8'h00 && rd_data == 8'h00);
endmodule

// File: rtl/hotspot_capture.sv
module hotspot_capture import hs_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_strobe,
  input  logic [12:0]   bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_rnw,
  input  logic          irq_ack,
  input  logic          win_en,
  input  logic [3:0]    aud_sample,
  input  logic          cmd_ready,
  input  logic          cmd_idle,
  output logic          irq_req,
  output logic          irq_overrun,
  output logic [7:0]    cap_tag,
  output logic [7:0]    cap_data,
  output logic [7:0]    rd_data,
  output logic [7:0]    rd_oe
);
  logic          s_vld, s_rnw;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  logic          trig_hit;
  logic [DW-1:0] trig_tag, trig_pay;

  hs_stage u_stage (
    .clk(clk), .rst_n(rst_n), .strobe(bus_strobe), .addr(bus_addr),
    .data(bus_wdata), .rnw(bus_rnw), .s_vld(s_vld), .s_addr(s_addr),
    .s_data(s_data), .s_rnw(s_rnw));

  hs_decode #(.HOT_PAGE(5'h1F)) u_decode (
    .s_vld(s_vld), .s_addr(s_addr), .s_data(s_data), .s_rnw(s_rnw),
    .hit(trig_hit), .hit_tag(trig_tag), .hit_pay(trig_pay));

  hs_capture u_capture (
    .clk(clk), .rst_n(rst_n), .hit(trig_hit), .hit_tag(trig_tag),
    .hit_pay(trig_pay), .ack(irq_ack), .irq(irq_req), .ovr(irq_overrun),
    .tag_q(cap_tag), .pay_q(cap_data));

  hs_rdwin u_rdwin (
    .clk(clk), .rst_n(rst_n), .en(win_en), .addr(bus_addr), .rnw(bus_rnw),
    .sample(aud_sample), .ready(cmd_ready), .idle(cmd_idle),
    .rd_data(rd_data), .rd_oe(rd_oe));

  p_hit_needs_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> $past(bus_strobe));
  p_rise_from_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(trig_hit));
endmodule

// File: tb/test_hotspot_capture.sv
module test_hotspot_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_strobe = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rnw = 1'b1;
  logic        irq_ack = 1'b0;
  logic        win_en = 1'b0;
  logic [3:0]  aud_sample = '0;
  logic        cmd_ready = 1'b0;
  logic        cmd_idle = 1'b0;
  logic        irq_req, irq_overrun;
  logic [7:0]  cap_tag, cap_data, rd_data, rd_oe;

  always #5 clk = ~clk;

  hotspot_capture i_hotspot_capture (.*);

  typedef struct {
    logic irq; logic ovr; logic [7:0] tag; logic [7:0] dat; string rq;
  } exp_t;
  exp_t sbq[$];
  event sample_ev;
  int n_chk = 0, n_fail = 0;

  logic m_irq = 0, m_ovr = 0;
  logic [7:0] m_tag = 0, m_dat = 0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // bench-side region model, written from the requirements
  task automatic model(input logic stb, input logic [12:0] a, input logic [7:0] d,
                       input logic rnw, input logic ak);
    logic hit; logic [7:0] t, p;
    hit = 0; t = 0; p = d;
    if (stb) begin
      if (a >= 13'h1F00) begin hit = 1; t = a[7:0]; end
      else if (!rnw && a >= 13'h0030 && a < 13'h0040) begin hit = 1; t = {4'h0, a[3:0]}; end
      else if (!rnw && a >= 13'h0040 && a < 13'h0080) begin hit = 1; t = 8'h00; end
      else if (!rnw && a >= 13'h0400 && a < 13'h1000) begin hit = 1; t = {4'h0, a[11:8]}; p = a[7:0]; end
    end
    if (ak) begin m_irq = 0; m_ovr = 0; end
    if (hit) begin
      if (!m_irq) begin m_irq = 1; m_tag = t; m_dat = p; end
      else m_ovr = 1;
    end
  endtask

  task automatic access(input logic stb, input logic [12:0] a, input logic [7:0] d,
                        input logic rnw, input logic ak, input string rq);
    exp_t e;
    @(negedge clk);
    bus_strobe = stb; bus_addr = a; bus_wdata = d; bus_rnw = rnw; irq_ack = 0;
    @(negedge clk);
    bus_strobe = 0; irq_ack = ak;
    @(negedge clk);
    irq_ack = 0;
    model(stb, a, d, rnw, ak);
    e.irq = m_irq; e.ovr = m_ovr; e.tag = m_tag; e.dat = m_dat; e.rq = rq;
    sbq.push_back(e);
    ->sample_ev;
    #1;
  endtask

  task automatic ack_only(input string rq);
    access(1'b0, 13'h0000, 8'h00, 1'b1, 1'b1, rq);
  endtask

  initial begin
    forever begin
      @(sample_ev);
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_chk++;
        if (irq_req !== e.irq || irq_overrun !== e.ovr || cap_tag !== e.tag || cap_data !== e.dat) begin
          n_fail++;
          $display("FAIL %s: irq/ovr/tag/data actual %0d/%0d/%h/%h expected %0d/%0d/%h/%h",
                   e.rq, irq_req, irq_overrun, cap_tag, cap_data, e.irq, e.ovr, e.tag, e.dat);
        end
      end
    end
  end

  task automatic rd_probe(input logic en, input logic [12:0] a, input logic rnw,
                          input logic rdy, input logic [3:0] smp, input logic idl,
                          input string rq);
    logic [7:0] eo, ed;
    @(negedge clk);
    win_en = en; bus_addr = a; bus_rnw = rnw; cmd_ready = rdy; aud_sample = smp; cmd_idle = idl;
    #1;
    if (en && rnw && (a == 13'h019 || a == 13'h01A)) begin
      eo = 8'h3F; ed = {2'b00, rdy, smp, idl};
    end else begin
      eo = 8'h00; ed = 8'h00;
    end
    n_chk++;
    if (rd_oe !== eo || rd_data !== ed) begin
      n_fail++;
      $display("FAIL %s: oe/data actual %h/%h expected %h/%h", rq, rd_oe, rd_data, eo, ed);
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    @(negedge clk);
    e.irq = 0; e.ovr = 0; e.tag = 0; e.dat = 0; e.rq = "R12";
    sbq.push_back(e); ->sample_ev; #1;

    access(1, 13'h1F42, 8'hA5, 0, 0, "R1 hot write");
    ack_only("R6 ack clears");
    access(1, 13'h1F07, 8'h3C, 1, 0, "R1 hot read");
    ack_only("R6");
    access(1, 13'h0035, 8'h99, 0, 0, "R2 nibble");
    ack_only("R6");
    access(1, 13'h003F, 8'h5A, 0, 0, "R2 top");
    ack_only("R6");
    access(1, 13'h0040, 8'h12, 0, 0, "R3 low");
    ack_only("R6");
    access(1, 13'h007F, 8'hE7, 0, 0, "R3 top");
    ack_only("R6");
    access(1, 13'h0ABC, 8'hFF, 0, 0, "R4 wide");
    ack_only("R6");
    access(1, 13'h0400, 8'h11, 0, 0, "R4 low edge");
    ack_only("R6");
    access(1, 13'h0FFF, 8'h22, 0, 0, "R4 top edge");
    ack_only("R6");

    access(1, 13'h0035, 8'h44, 1, 0, "R5 read nibble");
    access(1, 13'h0500, 8'h44, 1, 0, "R5 read wide");
    access(1, 13'h0080, 8'h44, 0, 0, "R5 above trig");
    access(1, 13'h002F, 8'h44, 0, 0, "R5 below nibble");
    access(1, 13'h03FF, 8'h44, 0, 0, "R5 below wide");
    access(1, 13'h1000, 8'h44, 0, 0, "R5 above wide");
    access(0, 13'h1F55, 8'h66, 0, 0, "R11 no strobe");

    access(1, 13'h1F11, 8'h01, 0, 0, "R1 pend start");
    access(1, 13'h0ABC, 8'h02, 0, 0, "R7 overrun keep");
    access(0, 13'h0000, 8'h00, 1, 0, "R6 held");
    access(1, 13'h0033, 8'h77, 0, 1, "R8 coincide");
    ack_only("R6 final");

    rd_probe(1, 13'h019, 1, 1, 4'hA, 0, "R9 lo");
    rd_probe(1, 13'h01A, 1, 0, 4'h5, 1, "R9 hi");
    rd_probe(0, 13'h019, 1, 1, 4'hF, 1, "R10 disabled");
    rd_probe(1, 13'h019, 0, 1, 4'hF, 1, "R10 write");
    rd_probe(1, 13'h018, 1, 1, 4'hF, 1, "R10 below");
    rd_probe(1, 13'h01B, 1, 1, 4'hF, 1, "R10 above");

    @(negedge clk);
    summary();
    $finish;
  end
endmodule